// File: doc/BRIEF.md
# PCI-Bound DMA Request Legality Guard

This block sits between the channel logic of a DMA engine and the bus master that starts cycles on the PCI bus. Each transfer request aimed at the PCI bus is presented together with a one-cycle valid strobe. A request describes its burst length in words, its signed address step in bytes, and whether it is a burst. It also gives its addressing mode (one address or two), its source and destination addresses, its byte count, and whether the far side is an external I/O device. The guard evaluates a fixed set of legality rules on that strobe. One clock later it reports the result.

Any rule violation produces a single-cycle bus-error pulse and sets one sticky status flag per broken rule. A request that breaks a rule cannot be issued. A single-address request between an external I/O device and the PCI bus is also unsupported. That request is quietly dropped: it is blocked with no error and no flag. In both cases a single-cycle suppress pulse tells the master not to start the bus cycle. Software clears the flags by writing ones to a clear input.

Top module: `pci_burst_guard`

## Requirements
- R1: While reset is held and in the first cycle after it, bus_err, suppress and all four flags are 0.
- R2: A burst request (req_burst=1) with req_len greater than 8 sets flags[0] and raises bus_err; a length of exactly 8 is legal.
- R3: A burst request whose req_step, read as a two's-complement byte value, equals -4 (8'hFC at the default width) sets flags[1] and raises bus_err.
- R4: A burst request with req_step equal to 0 sets flags[2] and raises bus_err.
- R5: A dual-address burst (req_dual=1, req_burst=1) sets flags[3] and raises bus_err if the low two bits of req_src, req_dst or req_cnt are not all zero. A single-address burst is not checked for alignment.
- R6: A non-burst request (req_burst=0) is exempt from the length, step and alignment rules: it never sets a flag nor raises bus_err.
- R7: A single-address request (req_dual=0) with req_ext_io=1 raises suppress, raises no bus_err and changes no flag.
- R8: A request that breaks several rules sets all matching flags in the same cycle and raises bus_err for exactly one cycle.
- R9: bus_err and suppress are single-cycle pulses that appear in the cycle after the strobed request and only then. suppress is high whenever bus_err is high, and without a strobe both stay low whatever the request fields hold.
- R10: Flags stay set until cleared. A 1 in bit i of flag_clr clears flags[i] in the next cycle and leaves the other flags alone. If a violation sets a bit in the same cycle that its clear is written, the set wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle strobe marking a request to check |
| req_burst | input | 1 | 1 = burst transfer, 0 = single transfer |
| req_dual | input | 1 | 1 = dual-address mode, 0 = single-address mode |
| req_ext_io | input | 1 | 1 = the other side is an external I/O device |
| req_len | input | LEN_W (5) | Burst length in words |
| req_step | input | INC_W (8) | Signed address step in bytes |
| req_src | input | ADDR_W (32) | Source address |
| req_dst | input | ADDR_W (32) | Destination address |
| req_cnt | input | CNT_W (24) | Byte count |
| flag_clr | input | 4 | Write-one-to-clear mask for the flags |
| bus_err | output | 1 | One-cycle pulse: the request broke a rule |
| suppress | output | 1 | One-cycle pulse: do not start the bus cycle |
| flags | output | 4 | Sticky flags: [0] too long, [1] step -4, [2] step 0, [3] misaligned |

## Verification
Legal bursts at the length limit are set against bursts one word over it, which separates the boundary from an off-by-one comparison. Step values of -4, 0 and +4 on bursts and on single transfers show that each step rule is keyed to its own value and gated by the burst bit. Misalignment is put in the source, destination and count in turn, and in single-address mode, so each field and the mode gate are seen on their own. Requests that break several rules, strobes given back to back, fields left violating with no strobe, and clears given alone or together with a new violation tell merged reporting apart from pulse length, strobe gating, and the priority of set over clear.

// File: rtl/pbg_pkg.sv
// Package: shared flag indices and the flag vector type for the PCI request guard.
// Assumes four legality rules; the index order defines the bit order of the flags port.
package pbg_pkg;
    localparam int NUM_FLAGS = 4;
    localparam int FLAG_LONG = 0;   // burst longer than the limit
    localparam int FLAG_NEG  = 1;   // burst stepping downward by one word
    localparam int FLAG_ZERO = 2;   // burst with no address step
    localparam int FLAG_ALGN = 3;   // dual-address burst off a word boundary

    typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/pbg_rules.sv
// Module: pbg_rules
// Purely combinational evaluation of the legality rules for one request.
// Assumes the request fields are stable in the cycle they are strobed;
// the strobe itself is applied downstream, not here.
module pbg_rules
    import pbg_pkg::*;
#(
    parameter int LEN_W      = 5,
    parameter int INC_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 24,
    parameter int MAX_BURST  = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic              burst,
    input  logic              dual,
    input  logic              ext_io,
    input  logic [LEN_W-1:0]  len,
    input  logic [INC_W-1:0]  step,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [CNT_W-1:0]  cnt,
    output flag_vec_t         viol,
    output logic              drop
);
    localparam int ALIGN_BITS = $clog2(WORD_BYTES);
    localparam logic [LEN_W-1:0]  LEN_LIMIT = LEN_W'(MAX_BURST);
    localparam logic [INC_W-1:0]  DOWN_STEP = INC_W'(-WORD_BYTES);
    localparam logic [INC_W-1:0]  NO_STEP   = '0;
    localparam logic [ADDR_W-1:0] ADDR_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);
    localparam logic [CNT_W-1:0]  CNT_MASK  = CNT_W'((1 << ALIGN_BITS) - 1);

    logic misaligned;

    // Any address or count bit below the word boundary marks misalignment.
    always_comb begin
        misaligned = (|(src & ADDR_MASK)) | (|(dst & ADDR_MASK)) | (|(cnt & CNT_MASK));
    end

    // Apply each rule; only bursts are subject to them.
    always_comb begin
        viol            = '0;
        viol[FLAG_LONG] = burst && (len > LEN_LIMIT);
        viol[FLAG_NEG]  = burst && (step == DOWN_STEP);
        viol[FLAG_ZERO] = burst && (step == NO_STEP);
        viol[FLAG_ALGN] = burst && dual && misaligned;
    end

    // Unsupported pairing: one address, peer is an external I/O device.
    always_comb begin
        drop = !dual && ext_io;
    end
endmodule

// File: rtl/pbg_sticky.sv
// Module: pbg_sticky
// One sticky flag per rule, set by a strobed violation, cleared by a
// write-one mask. Assumes set takes priority over clear in the same cycle.
module pbg_sticky
    import pbg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe,
    input  flag_vec_t viol,
    input  flag_vec_t clr,
    output flag_vec_t flags
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        logic bit_q;

        // Hold the flag; a strobed violation sets it, its clear bit drops it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else if (strobe && viol[i]) begin
                bit_q <= 1'b1;
            end else if (clr[i]) begin
                bit_q <= 1'b0;
            end
        end

        assign flags[i] = bit_q;
    end
endmodule

// File: rtl/pbg_outreg.sv
// Module: pbg_outreg
// Registers the per-request result into one-cycle bus_err and suppress pulses.
// Assumes one strobe yields one result cycle; back-to-back strobes give back-to-back pulses.
module pbg_outreg
    import pbg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      strobe,
    input  flag_vec_t viol,
    input  logic      drop,
    output logic      bus_err,
    output logic      suppress
);
    logic any_viol;

    // Collapse all rule hits into one error condition.
    always_comb begin
        any_viol = |viol;
    end

    // Capture the pulses for the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_err  <= 1'b0;
            suppress <= 1'b0;
        end else begin
            bus_err  <= strobe && any_viol;
            suppress <= strobe && (any_viol || drop);
        end
    end
endmodule

// File: rtl/pci_burst_guard.sv
// Module: pci_burst_guard (top)
// Checks DMA requests bound for the PCI bus, pulses bus_err and suppress one
// cycle after the strobe, and keeps one sticky flag per broken rule.
// Assumes req_valid is a one-cycle strobe and flag_clr is written by software.
module pci_burst_guard
    import pbg_pkg::*;
#(
    parameter int LEN_W      = 5,
    parameter int INC_W      = 8,
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 24,
    parameter int MAX_BURST  = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_burst,
    input  logic              req_dual,
    input  logic              req_ext_io,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [INC_W-1:0]  req_step,
    input  logic [ADDR_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_dst,
    input  logic [CNT_W-1:0]  req_cnt,
    input  logic [3:0]        flag_clr,
    output logic              bus_err,
    output logic              suppress,
    output logic [3:0]        flags
);
    flag_vec_t viol;
    logic      drop;
    flag_vec_t flags_q;

    pbg_rules #(
        .LEN_W      (LEN_W),
        .INC_W      (INC_W),
        .ADDR_W     (ADDR_W),
        .CNT_W      (CNT_W),
        .MAX_BURST  (MAX_BURST),
        .WORD_BYTES (WORD_BYTES)
    ) u_rules (
        .burst  (req_burst),
        .dual   (req_dual),
        .ext_io (req_ext_io),
        .len    (req_len),
        .step   (req_step),
        .src    (req_src),
        .dst    (req_dst),
        .cnt    (req_cnt),
        .viol   (viol),
        .drop   (drop)
    );

    pbg_sticky u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (req_valid),
        .viol   (viol),
        .clr    (flag_clr),
        .flags  (flags_q)
    );

    pbg_outreg u_outreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (req_valid),
        .viol     (viol),
        .drop     (drop),
        .bus_err  (bus_err),
        .suppress (suppress)
    );

    assign flags = flags_q;
endmodule

// File: rtl/pbg_checker.sv
// Module: pbg_checker
// Temporal properties of the guard, bound to the top module below.
// Assumes the default-width encoding of the step port (two's complement bytes).
module pbg_checker #(
    parameter int LEN_W      = 5,
    parameter int INC_W      = 8,
    parameter int MAX_BURST  = 8,
    parameter int WORD_BYTES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_burst,
    input logic             req_dual,
    input logic             req_ext_io,
    input logic [LEN_W-1:0] req_len,
    input logic [INC_W-1:0] req_step,
    input logic [3:0]       flag_clr,
    input logic             bus_err,
    input logic             suppress,
    input logic [3:0]       flags
);
    // R2: over-long burst reported next cycle
    assert_long_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst && (req_len > LEN_W'(MAX_BURST))) |=> (bus_err && flags[0]));

    // R3: downward word step reported next cycle
    assert_neg_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst && (req_step == INC_W'(-WORD_BYTES))) |=> (bus_err && flags[1]));

    // R4: zero step reported next cycle
    assert_zero_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_burst && (req_step == '0)) |=> (bus_err && flags[2]));

    // R6: single transfers never raise an error
    assert_single_exempt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_burst) |=> !bus_err);

    // R7: dropped pairing is blocked quietly
    assert_quiet_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_burst && !req_dual && req_ext_io && (flag_clr == 4'b0))
        |=> (suppress && !bus_err && $stable(flags)));

    // R9: no strobe, no pulse
    assert_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!bus_err && !suppress));

    // R9: an error always blocks the cycle
    assert_err_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> suppress);

    // R10: without a clear, no set flag falls
    assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr == 4'b0) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

bind pci_burst_guard pbg_checker #(
    .LEN_W      (LEN_W),
    .INC_W      (INC_W),
    .MAX_BURST  (MAX_BURST),
    .WORD_BYTES (WORD_BYTES)
) u_pbg_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_burst  (req_burst),
    .req_dual   (req_dual),
    .req_ext_io (req_ext_io),
    .req_len    (req_len),
    .req_step   (req_step),
    .flag_clr   (flag_clr),
    .bus_err    (bus_err),
    .suppress   (suppress),
    .flags      (flags)
);

// File: tb/pci_burst_guard_bench.sv
`timescale 1ns/100ps
// Bench: behavioural reference model updated on each clock and compared with the outputs.
module pci_burst_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_burst = 1'b0, req_dual = 1'b0, req_ext_io = 1'b0;
    logic [4:0]  req_len = '0;
    logic [7:0]  req_step = '0;
    logic [31:0] req_src = '0, req_dst = '0;
    logic [23:0] req_cnt = '0;
    logic [3:0]  flag_clr = '0;
    logic        bus_err, suppress;
    logic [3:0]  flags;

    int checks = 0;
    int fails = 0;
    int exp_flags = 0;
    bit exp_err = 0, exp_sup = 0;

    pci_burst_guard u_pci_burst_guard (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_burst(req_burst),
        .req_dual(req_dual), .req_ext_io(req_ext_io), .req_len(req_len),
        .req_step(req_step), .req_src(req_src), .req_dst(req_dst), .req_cnt(req_cnt),
        .flag_clr(flag_clr), .bus_err(bus_err), .suppress(suppress), .flags(flags)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one request (or idle) for one clock, update the model, compare.
    task automatic cycle(input string tag, input bit v, input bit b, input bit d, input bit x,
                         input int len, input int stp, input int src, input int dst,
                         input int cnt, input int clr);
        int viol;
        bit mis;
        req_valid = v; req_burst = b; req_dual = d; req_ext_io = x;
        req_len = len[4:0]; req_step = stp[7:0]; req_src = src; req_dst = dst;
        req_cnt = cnt[23:0]; flag_clr = clr[3:0];
        @(posedge clk);
        mis  = ((src % 4) != 0) || ((dst % 4) != 0) || ((cnt % 4) != 0);
        viol = 0;
        if (b && len > 8)          viol = viol | 1;
        if (b && stp == -4)        viol = viol | 2;
        if (b && stp == 0)         viol = viol | 4;
        if (b && d && mis)         viol = viol | 8;
        if (!v) viol = 0;
        exp_flags = ((exp_flags & ~clr) | viol) & 15;
        exp_err = (viol != 0);
        exp_sup = v && ((viol != 0) || (!d && x));
        #1;
        check(tag, int'(bus_err), int'(exp_err), "bus_err");
        check(tag, int'(suppress), int'(exp_sup), "suppress");
        check(tag, int'(flags), exp_flags, "flags");
        @(negedge clk);
    endtask

    task automatic idle(input string tag, input int clr);
        cycle(tag, 0, 0, 0, 0, 0, 4, 0, 0, 0, clr);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", int'(bus_err), 0, "bus_err in reset");
        check("R1", int'(suppress), 0, "suppress in reset");
        check("R1", int'(flags), 0, "flags in reset");
        @(negedge clk);
        rst_n = 1'b1;
        idle("R1", 0);
        // length boundary
        cycle("R2", 1, 1, 1, 0, 8, 4, 32'h100, 32'h200, 32, 0);
        cycle("R2", 1, 1, 1, 0, 9, 4, 32'h100, 32'h200, 36, 0);
        idle("R9", 0);
        idle("R10", 0);
        idle("R10", 1);
        // step rules
        cycle("R3", 1, 1, 1, 0, 4, -4, 32'h40, 32'h80, 16, 0);
        cycle("R4", 1, 1, 0, 0, 4, 0, 32'h40, 32'h80, 16, 0);
        cycle("R3", 1, 1, 1, 0, 4, 4, 32'h40, 32'h80, 16, 0);
        idle("R10", 2);
        idle("R10", 15);
        // alignment per field and mode gate
        cycle("R5", 1, 1, 1, 0, 4, 4, 32'h41, 32'h80, 16, 0);
        idle("R5", 8);
        cycle("R5", 1, 1, 1, 0, 4, 4, 32'h40, 32'h82, 16, 0);
        idle("R5", 8);
        cycle("R5", 1, 1, 1, 0, 4, 4, 32'h40, 32'h80, 17, 0);
        idle("R5", 8);
        cycle("R5", 1, 1, 0, 0, 4, 4, 32'h43, 32'h81, 15, 0);
        // single transfers exempt
        cycle("R6", 1, 0, 1, 0, 20, 0, 32'h41, 32'h83, 7, 0);
        cycle("R6", 1, 0, 1, 0, 31, -4, 32'h40, 32'h80, 16, 0);
        // quiet drop, both burst states
        cycle("R7", 1, 0, 0, 1, 1, 4, 32'h40, 32'h80, 4, 0);
        cycle("R7", 1, 1, 0, 1, 4, 4, 32'h40, 32'h80, 16, 0);
        cycle("R7", 1, 0, 1, 1, 1, 4, 32'h40, 32'h80, 4, 0);
        // merged violations then pulse end
        cycle("R8", 1, 1, 1, 0, 16, 0, 32'h40, 32'h81, 16, 0);
        idle("R8", 0);
        idle("R8", 15);
        // set wins over clear in the same cycle
        cycle("R10", 1, 1, 1, 0, 9, 4, 32'h40, 32'h80, 16, 15);
        idle("R10", 0);
        idle("R10", 1);
        // back-to-back strobes and violating fields without strobe
        cycle("R9", 1, 1, 1, 0, 12, 4, 32'h40, 32'h80, 16, 0);
        cycle("R9", 1, 1, 1, 0, 4, 0, 32'h40, 32'h80, 16, 0);
        cycle("R9", 0, 1, 1, 0, 30, -4, 32'h41, 32'h83, 3, 0);
        cycle("R9", 0, 0, 0, 1, 1, 4, 0, 0, 4, 0);
        idle("R9", 15);
        idle("R1", 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule